// File: doc/BRIEF.md
# Palette and Pixel Format Unit

This block sits between the pixel fetch path and the output stage of a display pipeline. Each cycle it may accept one framebuffer pixel word with a valid strobe and, exactly two cycles later, produces one registered 24-bit RGB colour with its own valid strobe. A configuration register selects how the pixel word is read. An 8-bit pixel is an index into a 256-entry colour table. A 16-bit pixel is unpacked from one of three packings and widened to 8 bits per channel. A 24-bit pixel either passes straight through or has each channel corrected through the colour table, which then acts as a gamma table.

Software reaches the block through a small write-only register bus. The colour table is loaded indirectly: software writes a table index once, then writes colours one after another. The index advances by one after each colour write, so a whole table loads as a single stream of data writes. Fetch, timing generation and sync are handled elsewhere.

Top module: `pxl_color_unit`

## Requirements
- R1: After reset, out_valid is 0, out_rgb is 0, the table index is 0 and the configuration selects 8-bit indexed mode with 5-6-5 packing and no bypass.
- R2: A bus write to offset 0x08 loads the configuration from reg_wdata: bits [1:0] pick the mode (0 = 8-bit indexed, 1 = 16-bit, 2 or 3 = 24-bit), bits [3:2] pick the 16-bit packing (0 = 5-6-5, 1 = 5-5-5, 2 = 4-4-4, 3 = 5-6-5) and bit 4 selects bypass for 24-bit mode.
- R3: In 8-bit mode, in_pixel[7:0] indexes the table and out_rgb is the whole 24-bit entry; in_pixel[23:8] has no effect.
- R4: A write to offset 0x70 sets the table index to reg_wdata[7:0]; a write to offset 0x74 stores reg_wdata[23:0] (red [23:16], green [15:8], blue [7:0]) at the current index, then adds one to the index, wrapping from 255 to 0.
- R5: In 16-bit mode with 5-6-5 packing, red is in_pixel[15:11], green [10:5], blue [4:0]; each channel is widened to 8 bits by copying its top bits into the empty low bits.
- R6: In 16-bit mode with 5-5-5 packing, red is in_pixel[14:10], green [9:5], blue [4:0], widened by copying top bits; in_pixel[15] has no effect.
- R7: In 16-bit mode with 4-4-4 packing, red is in_pixel[11:8], green [7:4], blue [3:0], each nibble repeated to fill 8 bits; in_pixel[23:12] has no effect.
- R8: In 24-bit mode with bypass set, out_rgb equals in_pixel.
- R9: In 24-bit mode with bypass clear, red out is the red byte of the entry indexed by in_pixel[23:16], green out is the green byte of the entry indexed by in_pixel[15:8], blue out is the blue byte of the entry indexed by in_pixel[7:0].
- R10: out_valid is high exactly two cycles after each cycle in which in_valid is high, in every mode, including back-to-back pixels.
- R11: out_rgb keeps its value in every cycle where out_valid is low.
- R12: A lookup issued in the same cycle as a colour write to the same entry returns the old colour; a lookup in the next cycle returns the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 24 | Register write data |
| in_valid | input | 1 | Pixel word valid |
| in_pixel | input | 24 | Framebuffer pixel word |
| out_valid | output | 1 | Output colour valid |
| out_rgb | output | 24 | Output colour, red [23:16], green [15:8], blue [7:0] |

## Verification
Every 5-6-5 code and every 5-5-5 code is swept, so a wrong field slice or a widening that pads with zeros instead of copying top bits shows up as a wrong low channel bit; the 5-5-5 sweep toggles bit 15, which a decoder that treats it as red would expose. The table is loaded by one run of data writes with no index write, so a missing increment, a missing wrap to entry 0 or a nonzero reset index leaves the wrong colours in later 8-bit lookups. A colour write and a lookup of the same entry are placed in one cycle, which catches a table that forwards the new value early, and gamma lookups mixing three different entries catch ports that share an index. Idle gaps inside the streams catch an output that drifts or a valid strobe at the wrong delay.

// File: rtl/pxl_color_pkg.sv
package pxl_color_pkg;

  localparam int CH_W   = 8;
  localparam int N_CH   = 3;
  localparam int RGB_W  = N_CH * CH_W;
  localparam int CFG_W  = 5;

  localparam logic [7:0] OFS_CFG      = 8'h08;
  localparam logic [7:0] OFS_PAL_IDX  = 8'h70;
  localparam logic [7:0] OFS_PAL_DATA = 8'h74;

  typedef enum logic [1:0] {
    MODE_IDX8      = 2'd0,
    MODE_RGB16     = 2'd1,
    MODE_RGB24     = 2'd2,
    MODE_RGB24_ALT = 2'd3
  } disp_mode_e;

  typedef enum logic [1:0] {
    PK_565     = 2'd0,
    PK_555     = 2'd1,
    PK_444     = 2'd2,
    PK_565_ALT = 2'd3
  } pack16_e;

  typedef enum logic [1:0] {
    SRC_INDEX  = 2'd0,
    SRC_GAMMA  = 2'd1,
    SRC_DIRECT = 2'd2
  } src_sel_e;

  typedef struct packed {
    logic       bypass;
    pack16_e    pack;
    disp_mode_e mode;
  } cfg_t;

endpackage

// File: rtl/pxl_color_regs.sv
module pxl_color_regs
  import pxl_color_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int REG_AW = 8,
  parameter int REG_DW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output cfg_t              cfg,
  output logic [IDX_W-1:0]  pal_idx,
  output logic              pal_we,
  output logic [IDX_W-1:0]  pal_widx,
  output logic [RGB_W-1:0]  pal_wdata
);

  localparam logic [REG_AW-1:0] A_CFG  = REG_AW'(OFS_CFG);
  localparam logic [REG_AW-1:0] A_IDX  = REG_AW'(OFS_PAL_IDX);
  localparam logic [REG_AW-1:0] A_DATA = REG_AW'(OFS_PAL_DATA);

  logic             hit_cfg, hit_idx, hit_data;
  logic             cfg_en, idx_en;
  cfg_t             cfg_nxt;
  logic [IDX_W-1:0] idx_nxt;

  always_comb begin
    hit_cfg  = reg_wr && (reg_addr == A_CFG);
    hit_idx  = reg_wr && (reg_addr == A_IDX);
    hit_data = reg_wr && (reg_addr == A_DATA);

    cfg_en  = hit_cfg;
    cfg_nxt = cfg_t'(reg_wdata[CFG_W-1:0]);

    idx_en  = hit_idx || hit_data;
    idx_nxt = hit_idx ? reg_wdata[IDX_W-1:0] : pal_idx + IDX_W'(1);

    pal_we    = hit_data;
    pal_widx  = pal_idx;
    pal_wdata = reg_wdata[RGB_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '{bypass: 1'b0, pack: PK_565, mode: MODE_IDX8};
      pal_idx <= '0;
    end else begin
      if (cfg_en) cfg     <= cfg_nxt;
      if (idx_en) pal_idx <= idx_nxt;
    end
  end

endmodule

// File: rtl/pxl_color_palette.sv
module pxl_color_palette #(
  parameter int IDX_W = 8,
  parameter int DW    = 24,
  parameter int NRD   = 3
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [IDX_W-1:0]           widx,
  input  logic [DW-1:0]              wdata,
  input  logic [NRD-1:0]             rd_en,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
  output logic [NRD-1:0][DW-1:0]     rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rd_en[p]) rd_data[p] <= mem[rd_idx[p]];
    end
  end

endmodule

// File: rtl/pxl_color_unpack16.sv
module pxl_color_unpack16
  import pxl_color_pkg::*;
(
  input  pack16_e          pack,
  input  logic [15:0]      word,
  output logic [RGB_W-1:0] rgb
);

  function automatic logic [CH_W-1:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [CH_W-1:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [CH_W-1:0] widen4(input logic [3:0] v);
    return {v, v};
  endfunction

  always_comb begin
    case (pack)
      PK_555:  rgb = {widen5(word[14:10]), widen5(word[9:5]), widen5(word[4:0])};
      PK_444:  rgb = {widen4(word[11:8]), widen4(word[7:4]), widen4(word[3:0])};
      default: rgb = {widen5(word[15:11]), widen6(word[10:5]), widen5(word[4:0])};
    endcase
  end

endmodule

// File: rtl/pxl_color_unit.sv
module pxl_color_unit
  import pxl_color_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int REG_AW = 8,
  parameter int REG_DW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              in_valid,
  input  logic [RGB_W-1:0]  in_pixel,
  output logic              out_valid,
  output logic [RGB_W-1:0]  out_rgb
);

  cfg_t                          cfg;
  logic [IDX_W-1:0]              pal_idx;
  logic                          pal_we;
  logic [IDX_W-1:0]              pal_widx;
  logic [RGB_W-1:0]              pal_wdata;
  logic [N_CH-1:0]               rd_en;
  logic [N_CH-1:0][IDX_W-1:0]    rd_idx;
  logic [N_CH-1:0][RGB_W-1:0]    rd_data;
  logic [RGB_W-1:0]              rgb16;

  src_sel_e          s0_sel, s1_sel;
  logic [RGB_W-1:0]  s0_direct, s1_direct;
  logic              s1_valid;
  logic [RGB_W-1:0]  out_nxt;

  pxl_color_regs #(
    .IDX_W (IDX_W),
    .REG_AW(REG_AW),
    .REG_DW(REG_DW)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .cfg      (cfg),
    .pal_idx  (pal_idx),
    .pal_we   (pal_we),
    .pal_widx (pal_widx),
    .pal_wdata(pal_wdata)
  );

  pxl_color_palette #(
    .IDX_W(IDX_W),
    .DW   (RGB_W),
    .NRD  (N_CH)
  ) u_pal (
    .clk    (clk),
    .we     (pal_we),
    .widx   (pal_widx),
    .wdata  (pal_wdata),
    .rd_en  (rd_en),
    .rd_idx (rd_idx),
    .rd_data(rd_data)
  );

  pxl_color_unpack16 u_unpack (
    .pack(cfg.pack),
    .word(in_pixel[15:0]),
    .rgb (rgb16)
  );

  // Stage 0: decode the pixel word and issue table reads.
  always_comb begin
    s0_sel    = SRC_INDEX;
    s0_direct = '0;
    rd_en     = '0;
    rd_idx    = '0;
    case (cfg.mode)
      MODE_IDX8: begin
        rd_en[0]  = in_valid;
        rd_idx[0] = in_pixel[IDX_W-1:0];
      end
      MODE_RGB16: begin
        s0_sel    = SRC_DIRECT;
        s0_direct = rgb16;
      end
      default: begin
        if (cfg.bypass) begin
          s0_sel    = SRC_DIRECT;
          s0_direct = in_pixel;
        end else begin
          s0_sel = SRC_GAMMA;
          for (int p = 0; p < N_CH; p++) begin
            rd_en[p]  = in_valid;
            rd_idx[p] = IDX_W'(in_pixel[(N_CH-1-p)*CH_W +: CH_W]);
          end
        end
      end
    endcase
  end

  // Stage 1 registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_sel    <= SRC_INDEX;
      s1_direct <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sel    <= s0_sel;
        s1_direct <= s0_direct;
      end
    end
  end

  // Stage 1 output select.
  always_comb begin
    case (s1_sel)
      SRC_INDEX:  out_nxt = rd_data[0];
      SRC_GAMMA: begin
        for (int p = 0; p < N_CH; p++) begin
          out_nxt[(N_CH-1-p)*CH_W +: CH_W] = rd_data[p][(N_CH-1-p)*CH_W +: CH_W];
        end
      end
      default:    out_nxt = s1_direct;
    endcase
  end

  // Stage 2 output registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_rgb <= out_nxt;
    end
  end

endmodule

// File: rtl/pxl_color_unit_chk.sv
module pxl_color_unit_chk
  import pxl_color_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int REG_AW = 8,
  parameter int REG_DW = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_wdata,
  input logic              in_valid,
  input logic              out_valid,
  input logic [RGB_W-1:0]  out_rgb,
  input logic [IDX_W-1:0]  pal_idx
);

  logic sh1, sh2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh1 <= 1'b0;
      sh2 <= 1'b0;
    end else begin
      sh1 <= in_valid;
      sh2 <= sh1;
    end
  end

  // R10: output strobe trails the input strobe by two cycles.
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == sh2);

  // R11: colour holds while no output is valid.
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_rgb));

  // R4: each colour write advances the table index by one.
  a_r4_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_AW'(OFS_PAL_DATA))
      |=> pal_idx == $past(pal_idx) + IDX_W'(1));

  // R4: an index write loads the table index.
  a_r4_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_AW'(OFS_PAL_IDX))
      |=> pal_idx == $past(reg_wdata[IDX_W-1:0]));

endmodule

bind pxl_color_unit pxl_color_unit_chk #(
  .IDX_W (IDX_W),
  .REG_AW(REG_AW),
  .REG_DW(REG_DW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_rgb  (out_rgb),
  .pal_idx  (pal_idx)
);

// File: tb/pxl_color_unit_bench.sv
module pxl_color_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [23:0] reg_wdata;
  logic        in_valid;
  logic [23:0] in_pixel;
  logic        out_valid;
  logic [23:0] out_rgb;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [23:0] model [256];

  logic        ev1 = 1'b0, ev2 = 1'b0;
  logic [23:0] ed1 = '0, ed2 = '0, last_rgb = '0;
  string       et1 = "", et2 = "";

  pxl_color_unit u_pxl_color_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .in_valid (in_valid),
    .in_pixel (in_pixel),
    .out_valid(out_valid),
    .out_rgb  (out_rgb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary_and_end();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000) begin
      errors++;
      $display("FAIL watchdog actual %0d cycles expected completion", cycles);
      summary_and_end();
    end
  end

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: check the output due now, then drive new inputs.
  task automatic cyc(input logic v, input logic [23:0] pix, input logic [23:0] exp,
                     input string tag, input logic we, input logic [7:0] a,
                     input logic [23:0] d);
    @(negedge clk);
    check("R10", {23'b0, out_valid}, {23'b0, ev2});
    if (ev2) begin
      check(et2, out_rgb, ed2);
      last_rgb = ed2;
    end else begin
      check("R11", out_rgb, last_rgb);
    end
    ev2 = ev1; ed2 = ed1; et2 = et1;
    ev1 = v;   ed1 = exp; et1 = tag;
    in_valid  = v;
    in_pixel  = pix;
    reg_wr    = we;
    reg_addr  = a;
    reg_wdata = d;
  endtask

  task automatic pix(input logic [23:0] p, input logic [23:0] exp, input string tag);
    cyc(1'b1, p, exp, tag, 1'b0, 8'h00, 24'h0);
  endtask

  task automatic idle();
    cyc(1'b0, 24'h0, 24'h0, "", 1'b0, 8'h00, 24'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [23:0] d);
    cyc(1'b0, 24'h0, 24'h0, "", 1'b1, a, d);
  endtask

  // R2: mode [1:0], packing [3:2], bypass [4] at offset 0x08.
  task automatic set_cfg(input logic [1:0] mode, input logic [1:0] pk, input logic byp);
    wr(8'h08, {19'b0, byp, pk, mode});
  endtask

  function automatic logic [23:0] palf(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b ^ 8'hA5, b + 8'd17, ~b};
  endfunction

  function automatic logic [23:0] exp565(input logic [15:0] w);
    logic [4:0] r, b;
    logic [5:0] g;
    r = w[15:11]; g = w[10:5]; b = w[4:0];
    return {r, r[4:2], g, g[5:4], b, b[4:2]};
  endfunction

  function automatic logic [23:0] exp555(input logic [15:0] w);
    logic [4:0] r, g, b;
    r = w[14:10]; g = w[9:5]; b = w[4:0];
    return {r, r[4:2], g, g[4:2], b, b[4:2]};
  endfunction

  function automatic logic [23:0] exp444(input logic [15:0] w);
    return {w[11:8], w[11:8], w[7:4], w[7:4], w[3:0], w[3:0]};
  endfunction

  function automatic logic [23:0] expgam(input logic [23:0] p);
    logic [23:0] er, eg, eb;
    er = model[p[23:16]]; eg = model[p[15:8]]; eb = model[p[7:0]];
    return {er[23:16], eg[15:8], eb[7:0]};
  endfunction

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    in_valid = 1'b0; in_pixel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of the outputs.
    @(negedge clk);
    check("R1", {23'b0, out_valid}, 24'h0);
    check("R1", out_rgb, 24'h0);

    // R1/R4: load the whole table with data writes only; index starts at 0.
    for (int i = 0; i < 256; i++) begin
      wr(8'h74, palf(i));
      model[i] = palf(i);
    end

    // R3: 8-bit lookups in the reset configuration, junk in upper bits.
    for (int i = 0; i < 256; i++) begin
      pix({8'(i * 7), 8'(i * 13), 8'(i)}, model[i], "R3");
      if (i % 5 == 4) idle();
    end
    idle();

    // R4: index wrapped to 0 after 256 writes.
    wr(8'h74, 24'hA1B2C3);
    model[0] = 24'hA1B2C3;
    pix(24'hFFFF00, model[0], "R4");
    pix(24'h000001, model[1], "R4");

    // R4: explicit index write, then increment.
    wr(8'h70, 24'h0000C8);
    wr(8'h74, 24'h123456);
    wr(8'h74, 24'h654321);
    model[200] = 24'h123456;
    model[201] = 24'h654321;
    pix(24'h0000C8, model[200], "R4");
    pix(24'h0000C9, model[201], "R4");
    pix(24'h0000CA, model[202], "R4");

    // R12: same-cycle write and lookup of entry 50.
    wr(8'h70, 24'h000032);
    cyc(1'b1, 24'h000032, model[50], "R12", 1'b1, 8'h74, 24'h0F1E2D);
    model[50] = 24'h0F1E2D;
    pix(24'h000032, model[50], "R12");
    idle(); idle(); idle();

    // R5: full 5-6-5 sweep, back to back.
    set_cfg(2'd1, 2'd0, 1'b0);
    for (int i = 0; i < 65536; i++) pix({8'(i >> 3), 16'(i)}, exp565(16'(i)), "R5");

    // R6: 5-5-5 sweep with bit 15 toggled.
    set_cfg(2'd1, 2'd1, 1'b0);
    for (int i = 0; i < 32768; i++) begin
      logic [15:0] w;
      w = {1'(i ^ (i >> 3)), 15'(i)};
      pix({8'hC3, w}, exp555(w), "R6");
    end

    // R7: 4-4-4 sweep with junk above bit 11.
    set_cfg(2'd1, 2'd2, 1'b0);
    for (int i = 0; i < 4096; i++) begin
      logic [23:0] p;
      p = {12'(i * 37), 12'(i)};
      pix(p, exp444(p[15:0]), "R7");
      if (i % 97 == 0) idle();
    end

    // R2: packing code 3 decodes as 5-6-5.
    set_cfg(2'd1, 2'd3, 1'b0);
    for (int i = 0; i < 64; i++) pix(24'(i * 1021), exp565(16'(i * 1021)), "R2");

    // R8: 24-bit bypass.
    set_cfg(2'd2, 2'd0, 1'b1);
    for (int i = 0; i < 4096; i++) pix(24'(i * 4099), 24'(i * 4099), "R8");

    // R2: mode code 3 acts as 24-bit.
    set_cfg(2'd3, 2'd0, 1'b1);
    for (int i = 0; i < 32; i++) pix(24'(i * 524287), 24'(i * 524287), "R2");

    // R9: 24-bit gamma through the table, three distinct entries per pixel.
    set_cfg(2'd2, 2'd0, 1'b0);
    for (int i = 0; i < 256; i++) begin
      logic [23:0] p;
      p = {8'(i), 8'(i + 85), 8'(i + 170)};
      pix(p, expgam(p), "R9");
      if (i % 11 == 0) idle();
    end

    // R11: output holds while idle.
    repeat (6) idle();

    summary_and_end();
  end

endmodule